// File: doc/BRIEF.md
# Immediate Word Serial Streamer

This engine sends a 32-bit immediate word out as a stream of small groups, one group for each cycle on which the clock-enable input is high. The group size is 1, 2 or 4 bits, and a mode code picks it. A single order-control bit in the mode word picks between two output orders. When the bit is clear, the word leaves as one value, lowest group first. When the bit is set, the bytes still leave lowest first, but the groups inside each byte are reversed. The order bit never produces a whole-word most-significant-first stream.

A one-cycle start pulse latches the operand and the mode word. The engine then holds busy until the transfer ends. After the last group has been shown for one enable period, it raises done for a single cycle. A start that arrives during a transfer is ignored. A start with an unsupported mode code leaves the engine idle.

Top module: `imm_stream_engine`

## Requirements
- R1: After reset, busy, done and every bit of dout are 0.
- R2: Mode code 4'b0100 in mode_word[3:0] with mode_word[16] clear sends 32 single bits on dout[0], operand bit 0 first and bit 31 last.
- R3: Mode code 4'b0100 with mode_word[16] set sends operand bits 7..0, then 15..8, then 23..16, then 31..24, each on dout[0].
- R4: Mode code 4'b0101 sends 16 two-bit groups on dout[1:0]. With bit 16 clear they go lowest group first. With bit 16 set, the four groups inside each byte go highest first, and bytes go lowest first. A group's higher bit is always on dout[1].
- R5: Mode code 4'b0110 sends 8 nibbles on dout[3:0]. With bit 16 clear they go lowest nibble first. With bit 16 set, the high nibble of each byte goes before the low nibble, and bytes go lowest first.
- R6: Each clock edge with clk_en high moves dout to the next group. Edges with clk_en low leave dout unchanged.
- R7: busy rises on the edge that accepts a start and stays high until the transfer ends. On the first enabled edge after the last group, done pulses high for one cycle and busy falls on that same edge.
- R8: A start that arrives while busy is high does not change the stream in progress.
- R9: A start whose mode code is not 4'b0100, 4'b0101 or 4'b0110 leaves busy low and dout at 0.
- R10: While the engine is idle, including after done, dout is 0. Bits of dout above the group width are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to latch operand and mode word |
| mode_word | input | 32 | Mode code in [3:0], order-control bit in [16] |
| operand | input | 32 | Immediate data word |
| clk_en | input | 1 | Advances the stream by one group when high |
| dout | output | 4 | Current group, low-aligned |
| busy | output | 1 | High for the whole transfer |
| done | output | 1 | One-cycle pulse at transfer end |

## Verification
Each group size is run with the order bit clear and set. The operands use distinct byte values and uneven bit patterns, so a whole-word reversal, a byte swap or swapped bits inside a group each give a different stream from the correct one. Some transfers use a gapped enable pattern to separate group advance from clock edges. One transfer has a start with a different operand in its middle, which shows whether a busy engine reloads. An unsupported mode code and the idle state after done show whether the output is held low.

// File: rtl/imm_stream_pkg.sv
// Shared constants, group-width encoding and mode decode for the streamer.
// Assumes a 32-bit operand split into 8-bit bytes.
package imm_stream_pkg;
    localparam int WORD_W    = 32;
    localparam int BYTE_W    = 8;
    localparam int OUT_W     = 4;
    localparam int ORDER_BIT = 16;
    localparam int CNT_W     = $clog2(WORD_W) + 1;

    localparam logic [3:0] MODE_1B = 4'b0100;
    localparam logic [3:0] MODE_2B = 4'b0101;
    localparam logic [3:0] MODE_4B = 4'b0110;

    typedef enum logic [1:0] {GW1 = 2'd0, GW2 = 2'd1, GW4 = 2'd2} gw_e;

    function automatic logic mode_ok(input logic [3:0] m);
        return (m == MODE_1B) || (m == MODE_2B) || (m == MODE_4B);
    endfunction

    function automatic gw_e mode_gw(input logic [3:0] m);
        case (m)
            MODE_2B: return GW2;
            MODE_4B: return GW4;
            default: return GW1;
        endcase
    endfunction
endpackage

// File: rtl/stream_reorder.sv
// Reverses the order of GRP-bit groups inside every byte of a word.
// Bits inside one group keep their significance, and bytes keep their place.
// Purely combinational. Assumes GRP divides the byte width.
module stream_reorder #(
    parameter int WORD_W = 32,
    parameter int BYTE_W = 8,
    parameter int GRP    = 1
) (
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] dout
);
    localparam int NBYTE = WORD_W / BYTE_W;
    localparam int NGRP  = BYTE_W / GRP;

    for (genvar b = 0; b < NBYTE; b++) begin : g_byte
        for (genvar j = 0; j < NGRP; j++) begin : g_grp
            assign dout[b*BYTE_W + j*GRP +: GRP] = din[b*BYTE_W + (NGRP-1-j)*GRP +: GRP];
        end
    end
endmodule

// File: rtl/stream_ctrl.sv
// Transfer sequencer: counts the groups sent and produces busy and done.
// step is asserted on enabled cycles that still have a group to send.
// finish is asserted on the enabled cycle after the last group.
module stream_ctrl #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             clk_en,
    input  logic [CNT_W-1:0] total,
    output logic             busy,
    output logic             done,
    output logic             step,
    output logic             finish
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;

    // Decode whether this enabled cycle sends a group or closes the transfer.
    always_comb begin
        step   = busy && clk_en && (cnt != lim);
        finish = busy && clk_en && (cnt == lim);
    end

    // Sequencer state: busy flag, group counter, length limit and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            done <= 1'b0;
            cnt  <= '0;
            lim  <= '0;
        end else begin
            done <= 1'b0;
            if (load) begin
                busy <= 1'b1;
                cnt  <= '0;
                lim  <= total;
            end else if (step) begin
                cnt <= cnt + 1'b1;
            end else if (finish) begin
                busy <= 1'b0;
                done <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/stream_shifter.sv
// Holds the pre-ordered word and presents one group per step, lowest group first.
// Clears the output on finish. Assumes the word arrives already reordered.
module stream_shifter
    import imm_stream_pkg::*;
#(
    parameter int W  = 32,
    parameter int OW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic          finish,
    input  logic [W-1:0]  load_word,
    input  gw_e           load_gw,
    output logic [OW-1:0] dout
);
    logic [W-1:0] word;
    gw_e          gw;

    // Load the word, emit and shift one group per step, clear the output at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word <= '0;
            gw   <= GW1;
            dout <= '0;
        end else if (load) begin
            word <= load_word;
            gw   <= load_gw;
            dout <= '0;
        end else if (step) begin
            case (gw)
                GW2:     begin dout <= OW'(word[1:0]); word <= word >> 2; end
                GW4:     begin dout <= OW'(word[3:0]); word <= word >> 4; end
                default: begin dout <= OW'(word[0]);   word <= word >> 1; end
            endcase
        end else if (finish) begin
            dout <= '0;
        end
    end
endmodule

// File: rtl/imm_stream_engine.sv
// Top of the immediate-word streamer. Decodes the mode, reorders the operand
// for the order-control bit, and drives the sequencer and the shifter.
// Assumes start is one cycle wide. Starts while busy or with bad modes are dropped.
module imm_stream_engine
    import imm_stream_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [WORD_W-1:0]   mode_word,
    input  logic [WORD_W-1:0]   operand,
    input  logic                clk_en,
    output logic [OUT_W-1:0]    dout,
    output logic                busy,
    output logic                done
);
    logic [WORD_W-1:0] rev [3];
    logic [WORD_W-1:0] load_word;
    logic [CNT_W-1:0]  total;
    gw_e               gw;
    logic              load, step, finish;

    for (genvar k = 0; k < 3; k++) begin : g_rev
        stream_reorder #(.WORD_W(WORD_W), .BYTE_W(BYTE_W), .GRP(1 << k)) u_rev (
            .din (operand),
            .dout(rev[k])
        );
    end

    // Accept a start, pick the group width, length and ordered word.
    always_comb begin
        load = start && !busy && mode_ok(mode_word[3:0]);
        gw   = mode_gw(mode_word[3:0]);
        case (gw)
            GW2:     begin total = CNT_W'(WORD_W / 2); load_word = rev[1]; end
            GW4:     begin total = CNT_W'(WORD_W / 4); load_word = rev[2]; end
            default: begin total = CNT_W'(WORD_W);     load_word = rev[0]; end
        endcase
        if (!mode_word[ORDER_BIT]) load_word = operand;
    end

    stream_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .load(load), .clk_en(clk_en), .total(total),
        .busy(busy), .done(done), .step(step), .finish(finish)
    );

    stream_shifter #(.W(WORD_W), .OW(OUT_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(load), .step(step), .finish(finish),
        .load_word(load_word), .load_gw(gw), .dout(dout)
    );
endmodule

// File: rtl/imm_stream_chk.sv
// Property checker for the streamer, bound to the top module.
module imm_stream_chk
    import imm_stream_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [WORD_W-1:0] mode_word,
    input logic              clk_en,
    input logic [OUT_W-1:0]  dout,
    input logic              busy,
    input logic              done
);
    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
    // R7
    done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> (!busy && $past(busy)));
    // R7
    busy_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(start));
    // R6
    hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n) (busy && !clk_en) |=> $stable(dout));
    // R9
    bad_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && !mode_ok(mode_word[3:0])) |=> (!busy && dout == '0));
    // R10
    idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> dout == '0);
endmodule

bind imm_stream_engine imm_stream_chk u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_word(mode_word),
    .clk_en(clk_en), .dout(dout), .busy(busy), .done(done)
);

// File: tb/sim_imm_stream_engine.sv
module sim_imm_stream_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] mode_word = '0;
    logic [31:0] operand = '0;
    logic        clk_en = 1'b0;
    logic [3:0]  dout;
    logic        busy, done;
    int          checks = 0;
    int          errors = 0;

    always #5 clk = ~clk;

    imm_stream_engine u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .mode_word(mode_word),
        .operand(operand), .clk_en(clk_en), .dout(dout), .busy(busy), .done(done)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_group(input logic [31:0] op, input int gsz,
                                             input logic ord, input int k);
        int ng  = 8 / gsz;
        int b   = k / ng;
        int j   = k % ng;
        int src = ord ? (ng - 1 - j) : j;
        logic [31:0] v = (op >> (b*8 + src*gsz)) & ((32'd1 << gsz) - 1);
        return v[3:0];
    endfunction

    // Run one transfer. gapped: clk_en alternates; mid_start: a start mid-stream (R8).
    task automatic xfer(input string req, input logic [3:0] mcode, input logic ord,
                        input logic [31:0] op, input bit gapped, input bit mid_start);
        int gsz = (mcode == 4'b0101) ? 2 : (mcode == 4'b0110) ? 4 : 1;
        int n = 32 / gsz;
        int k = 0;
        int cyc = 0;
        int bad = 0;
        logic [3:0] prev = 4'h0;
        logic [3:0] first_act = 4'h0, first_exp = 4'h0;
        @(negedge clk);
        start = 1'b1; mode_word = {15'b0, ord, 12'b0, mcode}; operand = op; clk_en = 1'b0;
        @(negedge clk);
        start = 1'b0; operand = 32'h0;
        check({req, " R7 busy after start"}, 32'(busy), 32'd1);
        while (k < n) begin
            logic en = gapped ? logic'(cyc % 2) : 1'b1;
            clk_en = en;
            if (mid_start && k == 3) begin start = 1'b1; operand = ~op; end
            @(negedge clk);
            start = 1'b0;
            cyc++;
            if (en) begin
                if (dout !== exp_group(op, gsz, ord, k)) begin
                    if (bad == 0) begin first_act = dout; first_exp = exp_group(op, gsz, ord, k); end
                    bad++;
                end
                prev = dout;
                k++;
            end else if (dout !== prev) begin
                if (bad == 0) begin first_act = dout; first_exp = prev; end
                bad++;
            end
        end
        check({req, " stream"}, bad == 0 ? 32'(first_exp) : 32'(first_act), 32'(first_exp));
        clk_en = 1'b1;
        @(negedge clk);
        clk_en = 1'b0;
        check({req, " R7 done pulse"}, 32'(done), 32'd1);
        check({req, " R7 busy ends"}, 32'(busy), 32'd0);
        check({req, " R10 idle dout"}, 32'(dout), 32'd0);
        @(negedge clk);
        check({req, " R7 done one cycle"}, 32'(done), 32'd0);
    endtask

    task automatic t_reset;
        check("R1 busy", 32'(busy), 32'd0);
        check("R1 done", 32'(done), 32'd0);
        check("R1 dout", 32'(dout), 32'd0);
    endtask

    task automatic t_bad_mode;
        @(negedge clk);
        start = 1'b1; mode_word = 32'h0001_0007; operand = 32'hFFFF_FFFF; clk_en = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        clk_en = 1'b0;
        check("R9 busy stays low", 32'(busy), 32'd0);
        check("R9 dout low", 32'(dout), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        xfer("R2 1b lsb", 4'b0100, 1'b0, 32'hC3A5_1E81, 1'b0, 1'b0);
        xfer("R3 1b byte-msb", 4'b0100, 1'b1, 32'hC3A5_1E81, 1'b0, 1'b0);
        xfer("R4 2b plain", 4'b0101, 1'b0, 32'h9C4B_27E1, 1'b0, 1'b0);
        xfer("R4 2b rev", 4'b0101, 1'b1, 32'h9C4B_27E1, 1'b0, 1'b0);
        xfer("R5 4b plain", 4'b0110, 1'b0, 32'h7E3D_95A1, 1'b0, 1'b0);
        xfer("R5 4b rev", 4'b0110, 1'b1, 32'h7E3D_95A1, 1'b0, 1'b0);
        xfer("R6 gapped enable", 4'b0101, 1'b1, 32'h1234_8EC7, 1'b1, 1'b0);
        xfer("R8 start while busy", 4'b0100, 1'b1, 32'h0F35_A6C1, 1'b1, 1'b1);
        t_bad_mode();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule